// File: doc/BRIEF.md
# Multiple-Capture HDR Pixel Estimator

The block builds one high-dynamic-range value per pixel from a burst of non-destructive samples taken within a single frame. Exposure doubles from one capture to the next, from T up to 32T, which gives six captures. Samples arrive at the fast internal capture rate, tagged with the index of the pixel and the index of the capture. For every pixel the block keeps the newest sample that stayed below a programmable saturation threshold. It then scales that sample up to the longest exposure with a left shift. A pixel that saturated early therefore reports a large value, and a pixel that never saturated reports its final sample unchanged.

A frame opens with a start pulse, which wipes all per-pixel state. Samples then stream in, ordered by capture, for all pixels. When the sample for the last pixel at the last capture has been taken, the block sweeps its internal register file and emits one result per pixel in ascending order. Results come out at a slower pace, one every `RD_DIV` cycles. A single-cycle done pulse closes the frame. The method extends range at the bright end only; dim pixels simply report their longest-exposure sample.

Top module: `hdr_multicap_est`

## Requirements
- R1: While reset is applied and right after it is released, `out_valid` and `frame_done` are 0.
- R2: A pixel whose six samples all lie below `sat_thresh` reports its capture-5 sample unshifted, with `out_sat` = 0.
- R3: A pixel whose first saturated sample is at capture k (k ≥ 1) reports its capture k−1 sample shifted left by 5−(k−1), with `out_sat` = 0.
- R4: A sample equal to `sat_thresh` counts as saturated; only samples strictly below it are kept.
- R5: After a pixel saturates, its later samples are ignored, even when they fall back below the threshold.
- R6: When the capture-0 sample is saturated, the output is that sample shifted left by 5, and `out_sat` = 1. In every other case `out_sat` = 0.
- R7: `frame_start` clears all per-pixel state, so a pixel that gets no sample in the frame reports 0 with `out_sat` = 0.
- R8: Accepting the sample with `smp_pix` = NUM_PIX−1 and `smp_cap` = NUM_CAP−1 starts a readout. The readout gives exactly NUM_PIX results with `out_pix` = 0, 1, … in order, spaced RD_DIV cycles apart.
- R9: `frame_done` is high for exactly one cycle, the cycle after the last result of the readout.
- R10: The threshold is an input. Lowering it moves the chosen capture earlier for the same sample data, and the result follows R3 and R6 at the new threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that clears per-pixel state and aborts any readout |
| sat_thresh | input | PIX_W | Saturation level; samples at or above it are saturated (full scale 255 for 8 bits) |
| smp_valid | input | 1 | Sample strobe |
| smp_pix | input | IDX_W | Pixel index of the sample |
| smp_cap | input | CAP_W | Capture index of the sample, 0 = exposure T |
| smp_data | input | PIX_W | Sample value |
| out_valid | output | 1 | Result strobe |
| out_pix | output | IDX_W | Pixel index of the result |
| out_value | output | PIX_W+NUM_CAP−1 | Value normalised to the longest exposure |
| out_sat | output | 1 | Set when even capture 0 was saturated |
| frame_done | output | 1 | One-cycle pulse after the last result |

## Verification
The bench aims at the threshold boundary. It plants a sample exactly equal to the threshold and lets it be followed by a lower one. A design that compares with strict greater-than would keep the boundary sample. A design that does not lock the pixel would pick the later, lower sample at the wrong shift. It also saturates a pixel at capture 0; getting this wrong shows up as a zero or unflagged output instead of the sample scaled by 32. A frame in which only the last pixel is fed exposes stale state left over from the previous frame. Readout order, spacing and the placement of the done pulse are timed cycle by cycle, which catches an off-by-one in the sweep counter.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
   localparam int HDR_PIX_W   = 8;
   localparam int HDR_NUM_CAP = 6;
   localparam int HDR_NUM_PIX = 16;
   localparam int HDR_RD_DIV  = 2;

   typedef enum logic [0:0] {
      RD_IDLE = 1'b0,
      RD_RUN  = 1'b1
   } rd_state_e;
endpackage

// File: rtl/hdr_pix_store.sv
module hdr_pix_store #(
   parameter int PIX_W   = 8,
   parameter int NUM_PIX = 16,
   parameter int NUM_CAP = 6,
   localparam int IDX_W  = $clog2(NUM_PIX),
   localparam int CAP_W  = $clog2(NUM_CAP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_pix,
   input  logic [CAP_W-1:0] wr_cap,
   input  logic [PIX_W-1:0] wr_data,
   input  logic [PIX_W-1:0] thresh,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PIX_W-1:0] rd_smp,
   output logic [CAP_W-1:0] rd_cap,
   output logic             rd_satf
);
   logic [PIX_W-1:0] e_smp  [NUM_PIX];
   logic [CAP_W-1:0] e_cap  [NUM_PIX];
   logic             e_has  [NUM_PIX];
   logic             e_lock [NUM_PIX];
   logic             e_satf [NUM_PIX];

   logic is_sat;
   assign is_sat = (wr_data >= thresh);

   for (genvar i = 0; i < NUM_PIX; i++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_pix == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_smp[i]  <= '0;
            e_cap[i]  <= '0;
            e_has[i]  <= 1'b0;
            e_lock[i] <= 1'b0;
            e_satf[i] <= 1'b0;
         end else if (clr) begin
            e_smp[i]  <= '0;
            e_cap[i]  <= '0;
            e_has[i]  <= 1'b0;
            e_lock[i] <= 1'b0;
            e_satf[i] <= 1'b0;
         end else if (hit && !e_lock[i]) begin
            if (is_sat) begin
               e_lock[i] <= 1'b1;
               if (!e_has[i]) begin
                  e_smp[i]  <= wr_data;
                  e_cap[i]  <= wr_cap;
                  e_has[i]  <= 1'b1;
                  e_satf[i] <= 1'b1;
               end
            end else begin
               e_smp[i] <= wr_data;
               e_cap[i] <= wr_cap;
               e_has[i] <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rd_smp  = '0;
      rd_cap  = '0;
      rd_satf = 1'b0;
      for (int j = 0; j < NUM_PIX; j++) begin
         if (rd_idx == IDX_W'(j)) begin
            rd_smp  = e_smp[j];
            rd_cap  = e_cap[j];
            rd_satf = e_satf[j];
         end
      end
   end
endmodule

// File: rtl/hdr_scale.sv
module hdr_scale #(
   parameter int PIX_W   = 8,
   parameter int NUM_CAP = 6,
   localparam int CAP_W  = $clog2(NUM_CAP),
   localparam int OUT_W  = PIX_W + NUM_CAP - 1
) (
   input  logic [PIX_W-1:0] smp,
   input  logic [CAP_W-1:0] cap,
   output logic [OUT_W-1:0] val
);
   logic [CAP_W-1:0] sh;
   assign sh  = CAP_W'(NUM_CAP - 1) - cap;
   assign val = OUT_W'(smp) << sh;
endmodule

// File: rtl/hdr_readout.sv
module hdr_readout #(
   parameter int NUM_PIX = 16,
   parameter int RD_DIV  = 2,
   localparam int IDX_W  = $clog2(NUM_PIX),
   localparam int DIV_W  = (RD_DIV > 1) ? $clog2(RD_DIV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   output logic             fire,
   output logic [IDX_W-1:0] idx
);
   import hdr_pkg::*;

   rd_state_e        st_q;
   logic [IDX_W-1:0] idx_q;
   logic             active;

   assign active = (st_q == RD_RUN);
   assign idx    = idx_q;

   if (RD_DIV == 1) begin : g_nodiv
      assign fire = active;
   end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              div_q <= '0;
         else if (abort || start) div_q <= '0;
         else if (active)         div_q <= (div_q == DIV_W'(RD_DIV - 1)) ? '0 : div_q + 1'b1;
      end
      assign fire = active && (div_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RD_IDLE;
         idx_q <= '0;
      end else if (abort) begin
         st_q  <= RD_IDLE;
         idx_q <= '0;
      end else if (start) begin
         st_q  <= RD_RUN;
         idx_q <= '0;
      end else if (fire) begin
         if (idx_q == IDX_W'(NUM_PIX - 1)) st_q <= RD_IDLE;
         else                              idx_q <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/hdr_multicap_est.sv
module hdr_multicap_est #(
   parameter int PIX_W   = hdr_pkg::HDR_PIX_W,
   parameter int NUM_CAP = hdr_pkg::HDR_NUM_CAP,
   parameter int NUM_PIX = hdr_pkg::HDR_NUM_PIX,
   parameter int RD_DIV  = hdr_pkg::HDR_RD_DIV,
   localparam int IDX_W  = $clog2(NUM_PIX),
   localparam int CAP_W  = $clog2(NUM_CAP),
   localparam int OUT_W  = PIX_W + NUM_CAP - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic [PIX_W-1:0] sat_thresh,
   input  logic             smp_valid,
   input  logic [IDX_W-1:0] smp_pix,
   input  logic [CAP_W-1:0] smp_cap,
   input  logic [PIX_W-1:0] smp_data,
   output logic             out_valid,
   output logic [IDX_W-1:0] out_pix,
   output logic [OUT_W-1:0] out_value,
   output logic             out_sat,
   output logic             frame_done
);
   if (PIX_W < 1) begin : g_bad_pixw
      $error("PIX_W must be at least 1");
   end
   if (NUM_CAP < 2) begin : g_bad_ncap
      $error("NUM_CAP must be at least 2");
   end
   if (NUM_PIX < 2) begin : g_bad_npix
      $error("NUM_PIX must be at least 2");
   end
   if (RD_DIV < 1) begin : g_bad_div
      $error("RD_DIV must be at least 1");
   end

   logic             acc;
   logic             rd_start;
   logic             rd_fire;
   logic [IDX_W-1:0] rd_idx;
   logic [PIX_W-1:0] rd_smp;
   logic [CAP_W-1:0] rd_cap;
   logic             rd_satf;
   logic [OUT_W-1:0] scaled;

   assign acc = smp_valid && !frame_start && (smp_cap < CAP_W'(NUM_CAP))
                && (32'(smp_pix) < NUM_PIX);
   assign rd_start = acc && (smp_pix == IDX_W'(NUM_PIX - 1))
                     && (smp_cap == CAP_W'(NUM_CAP - 1));

   hdr_pix_store #(.PIX_W(PIX_W), .NUM_PIX(NUM_PIX), .NUM_CAP(NUM_CAP)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (frame_start),
      .wr_en   (acc),
      .wr_pix  (smp_pix),
      .wr_cap  (smp_cap),
      .wr_data (smp_data),
      .thresh  (sat_thresh),
      .rd_idx  (rd_idx),
      .rd_smp  (rd_smp),
      .rd_cap  (rd_cap),
      .rd_satf (rd_satf)
   );

   hdr_readout #(.NUM_PIX(NUM_PIX), .RD_DIV(RD_DIV)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rd_start),
      .abort (frame_start),
      .fire  (rd_fire),
      .idx   (rd_idx)
   );

   hdr_scale #(.PIX_W(PIX_W), .NUM_CAP(NUM_CAP)) u_scale (
      .smp (rd_smp),
      .cap (rd_cap),
      .val (scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_pix    <= '0;
         out_value  <= '0;
         out_sat    <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         out_valid  <= rd_fire;
         frame_done <= out_valid && (out_pix == IDX_W'(NUM_PIX - 1));
         if (rd_fire) begin
            out_pix   <= rd_idx;
            out_value <= scaled;
            out_sat   <= rd_satf;
         end
      end
   end
endmodule

// File: rtl/hdr_multicap_est_chk.sv
module hdr_multicap_est_chk #(
   parameter int PIX_W   = 8,
   parameter int NUM_CAP = 6,
   parameter int NUM_PIX = 16,
   parameter int RD_DIV  = 2,
   localparam int IDX_W  = $clog2(NUM_PIX),
   localparam int OUT_W  = PIX_W + NUM_CAP - 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             out_valid,
   input logic [IDX_W-1:0] out_pix,
   input logic [OUT_W-1:0] out_value,
   input logic             out_sat,
   input logic             frame_done
);
   logic [IDX_W-1:0] exp_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           exp_idx <= '0;
      else if (frame_start) exp_idx <= '0;
      else if (out_valid)   exp_idx <= (exp_idx == IDX_W'(NUM_PIX - 1)) ? '0 : exp_idx + 1'b1;
   end

   assert_pix_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_pix == exp_idx));

   if (RD_DIV > 1) begin : g_pace
      assert_pace_R8: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |=> !out_valid);
   end

   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_done) |-> ($past(out_valid) && $past(out_pix) == IDX_W'(NUM_PIX - 1)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   assert_sat_scaled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sat) |-> (out_value[NUM_CAP-2:0] == '0));

   assert_no_out_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !out_valid);
endmodule

bind hdr_multicap_est hdr_multicap_est_chk #(
   .PIX_W(PIX_W), .NUM_CAP(NUM_CAP), .NUM_PIX(NUM_PIX), .RD_DIV(RD_DIV)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .out_valid   (out_valid),
   .out_pix     (out_pix),
   .out_value   (out_value),
   .out_sat     (out_sat),
   .frame_done  (frame_done)
);

// File: tb/hdr_multicap_est_tb.sv
`timescale 1ns/1ps
module hdr_multicap_est_tb;
   localparam int PIX_W = 8, NCAP = 6, NPIX = 16, RDD = 2;
   localparam int IDX_W = $clog2(NPIX), CAP_W = $clog2(NCAP), OUT_W = PIX_W + NCAP - 1;

   logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, smp_valid = 1'b0;
   logic [PIX_W-1:0] sat_thresh = 8'd255, smp_data = '0;
   logic [IDX_W-1:0] smp_pix = '0;
   logic [CAP_W-1:0] smp_cap = '0;
   logic out_valid, out_sat, frame_done;
   logic [IDX_W-1:0] out_pix;
   logic [OUT_W-1:0] out_value;

   always #2.5 clk = ~clk;

   hdr_multicap_est #(.PIX_W(PIX_W), .NUM_CAP(NCAP), .NUM_PIX(NPIX), .RD_DIV(RDD)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sat_thresh(sat_thresh),
      .smp_valid(smp_valid), .smp_pix(smp_pix), .smp_cap(smp_cap), .smp_data(smp_data),
      .out_valid(out_valid), .out_pix(out_pix), .out_value(out_value), .out_sat(out_sat),
      .frame_done(frame_done));

   int n_chk = 0, n_bad = 0, cyc = 0;
   int frame_smp [NPIX][NCAP];
   string pix_tag [NPIX];
   int got_val [NPIX];
   bit got_sat [NPIX];
   int out_cnt, gap_bad, order_bad, last_cyc, done_cnt, done_cyc;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) if (rst_n) begin
      if (out_valid) begin
         if (out_cnt > 0 && cyc - last_cyc != RDD) gap_bad++;
         if (int'(out_pix) != out_cnt) order_bad++;
         got_val[out_pix] = int'(out_value);
         got_sat[out_pix] = out_sat;
         out_cnt++;
         last_cyc = cyc;
      end
      if (frame_done) begin
         done_cnt++;
         done_cyc = cyc;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Expected result straight from the requirements
   function automatic void model(input int p, input int th, input bit sent,
                                 output int v, output bit f);
      bit has = 0, lock = 0;
      int s = 0, kk = 0;
      f = 0;
      if (sent) begin
         for (int k = 0; k < NCAP; k++) begin
            if (!lock) begin
               if (frame_smp[p][k] >= th) begin
                  lock = 1;
                  if (!has) begin s = frame_smp[p][k]; kk = k; has = 1; f = 1; end
               end else begin
                  s = frame_smp[p][k]; kk = k; has = 1;
               end
            end
         end
      end
      v = s << (NCAP - 1 - kk);
   endfunction

   task automatic send_frame(input bit only_last);
      @(posedge clk); #1;
      frame_start = 1'b1;
      @(posedge clk); #1;
      frame_start = 1'b0;
      out_cnt = 0; gap_bad = 0; order_bad = 0; done_cnt = 0; done_cyc = -1; last_cyc = -1;
      for (int p = 0; p < NPIX; p++) begin got_val[p] = -1; got_sat[p] = 1'b0; end
      for (int k = 0; k < NCAP; k++) begin
         for (int p = 0; p < NPIX; p++) begin
            if (!only_last || p == NPIX - 1) begin
               smp_valid = 1'b1;
               smp_pix   = IDX_W'(p);
               smp_cap   = CAP_W'(k);
               smp_data  = PIX_W'(frame_smp[p][k]);
               @(posedge clk); #1;
            end
         end
      end
      smp_valid = 1'b0;
      for (int w = 0; w < 400 && done_cnt == 0; w++) @(posedge clk);
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic check_frame(input int th, input bit only_last);
      int v; bit f;
      for (int p = 0; p < NPIX; p++) begin
         model(p, th, !only_last || p == NPIX - 1, v, f);
         chk(got_val[p] == v, pix_tag[p], $sformatf("value pixel %0d", p), got_val[p], v);
         chk(got_sat[p] == f, pix_tag[p], $sformatf("sat flag pixel %0d", p), got_sat[p], f);
      end
      chk(out_cnt == NPIX, "R8", "result count", out_cnt, NPIX);
      chk(order_bad == 0, "R8", "out-of-order results", order_bad, 0);
      chk(gap_bad == 0, "R8", "wrong result spacing", gap_bad, 0);
      chk(done_cnt == 1, "R9", "done pulse cycles", done_cnt, 1);
      chk(done_cyc == last_cyc + 1, "R9", "done cycle", done_cyc, last_cyc + 1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(frame_done == 1'b0, "R1", "frame_done after reset", frame_done, 0);
   endtask

   task automatic t_dim;
      sat_thresh = 8'd255;
      for (int p = 0; p < NPIX; p++) begin
         pix_tag[p] = "R2";
         for (int k = 0; k < NCAP; k++) frame_smp[p][k] = (p + 1) * k + 1;
      end
      send_frame(1'b0);
      check_frame(255, 1'b0);
   endtask

   task automatic load_mixed;
      for (int p = 0; p < NPIX; p++) begin
         pix_tag[p] = "R3";
         for (int k = 0; k < NCAP; k++) begin
            int s = (8 * (p + 1) + 3) << k;
            frame_smp[p][k] = (s > 255) ? 255 : s;
         end
      end
      // boundary: equal to threshold, then a lower sample
      frame_smp[3][1] = 40; frame_smp[3][2] = 255; frame_smp[3][3] = 10;
      frame_smp[3][4] = 12; frame_smp[3][5] = 14; pix_tag[3] = "R4 R5";
      // first capture saturated, later fall back
      frame_smp[5][0] = 255; frame_smp[5][1] = 20; frame_smp[5][2] = 30;
      frame_smp[5][3] = 40; frame_smp[5][4] = 50; frame_smp[5][5] = 60; pix_tag[5] = "R6 R5";
      // near-threshold first capture, not saturated
      frame_smp[6][0] = 254; pix_tag[6] = "R3 R6";
   endtask

   task automatic t_mixed;
      sat_thresh = 8'd255;
      load_mixed();
      send_frame(1'b0);
      check_frame(255, 1'b0);
   endtask

   task automatic t_thresh;
      sat_thresh = 8'd100;
      load_mixed();
      for (int p = 0; p < NPIX; p++) pix_tag[p] = "R10";
      send_frame(1'b0);
      check_frame(100, 1'b0);
   endtask

   task automatic t_clear;
      sat_thresh = 8'd255;
      for (int p = 0; p < NPIX; p++) begin
         pix_tag[p] = "R7";
         for (int k = 0; k < NCAP; k++) frame_smp[p][k] = 7 * k + 2;
      end
      send_frame(1'b1);
      check_frame(255, 1'b1);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_dim();
      t_mixed();
      t_thresh();
      t_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule